// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Group

This block gathers level-sensitive interrupt lines from peripherals and presents them to a processor core. The core sees one interrupt request wire and an 8-bit vector bus. A group of high-numbered lines goes to a separate non-maskable request, which the mask cannot block. Software programs a single 32-bit mask word and can read back four status words through a small word-addressed register port.

The controller does not rank simultaneous sources. When one enabled source is active, the vector names that source. When several are active, the vector takes one shared value, and the handler reads the masked status word to choose the order in which it services them. Every path from the input lines and the mask register to the request and vector outputs is combinational. The mask register is the only stored state.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the mask word is 0. With the mask at 0, `irq_req` is low and `irq_vec` is 0 whatever the input lines are.
- R2: A write with `addr[4:2]` = 0 loads `wdata` into the mask on the clock edge. A read of that word then returns the new value.
- R3: Writes with `addr[4:2]` of 1 to 7 change nothing. The mask and all outputs stay as they were.
- R4: Input line n, for n from 1 to 29, drives bit n-1 of the raw pending word (read with `addr[4:2]` = 1). The bit follows the line level and is never latched. Line 0 has no effect anywhere.
- R5: The masked pending word (read with `addr[4:2]` = 2) always equals the raw pending word ANDed with the mask.
- R6: If exactly one masked pending bit is set, at position i (0 to 30), `irq_req` is high and `irq_vec` is 0x31 + i.
- R7: If two or more masked pending bits are set, `irq_req` is high and `irq_vec` is 0x30.
- R8: If no masked pending bit is set, `irq_req` is low and `irq_vec` is 0.
- R9: Lines 30 and 31 appear only in the NMI status word (read with `addr[4:2]` = 3), at bits 30 and 31. `nmi_req` is high exactly when that word is nonzero, and the mask has no effect on it.
- R10: The word at `addr[4:2]` = 4 reads as 0, and so do the words at 5 to 7.
- R11: `rdata`, `irq_req`, `irq_vec` and `nmi_req` respond to an input level change within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the mask register |
| rst_n | input | 1 | Active-low reset; clears the mask |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word, combinational |
| irq_lines | input | 32 | Level interrupt lines; 1–29 maskable, 30–31 non-maskable |
| irq_req | output | 1 | Maskable interrupt request to the core |
| irq_vec | output | 8 | Vector for the current request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
On every cycle the assertions check four things:
- The mask write and ignore rules.
- A zero vector whenever the request is low.
- A request-high vector that stays within the legal range.
- The non-maskable request tracking lines 30 and 31 regardless of the mask.

The remaining behaviours need the bench's scenarios, because each depends on a specific line pattern:
- The exact single-source vector numbering, including the line-to-bit offset.
- The switch to the shared vector when a second source appears.
- Line 0 having no effect.
- The zero reads from the spare words.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int          NMI_FIRST  = 30,
  parameter logic [7:0]  VEC_SHARED = 8'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] irq_lines,
  output logic        irq_req,
  output logic [7:0]  irq_vec,
  output logic        nmi_req
);

  localparam int SCAN_TOP = 30;

  logic [31:0] mask_q;
  logic [31:0] pend;
  logic [31:0] nmi_stat;
  logic [31:0] masked;
  logic [2:0]  widx;
  logic        found;
  logic [4:0]  first;
  logic        multi;
  logic        unused_ok;

  assign widx      = addr[4:2];
  assign unused_ok = ^{addr[1:0], irq_lines[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     mask_q <= '0;
    else if (wr_en && widx == 3'd0) mask_q <= wdata;

  for (genvar i = 0; i < 32; i++) begin : g_route
    if (i + 1 < NMI_FIRST) begin : g_pend
      assign pend[i] = irq_lines[i+1];
    end else begin : g_nopend
      assign pend[i] = 1'b0;
    end
    if (i >= NMI_FIRST) begin : g_nmi
      assign nmi_stat[i] = irq_lines[i];
    end else begin : g_nonmi
      assign nmi_stat[i] = 1'b0;
    end
  end

  assign masked  = pend & mask_q;
  assign multi   = (masked & (masked - 32'd1)) != '0;
  assign nmi_req = |nmi_stat;

  always_comb begin
    found = 1'b0;
    first = '0;
    for (int i = 0; i <= SCAN_TOP; i++)
      if (masked[i] && !found) begin
        found = 1'b1;
        first = 5'(i);
      end
  end

  assign irq_req = found;
  assign irq_vec = !found ? 8'h00 :
                   multi  ? VEC_SHARED :
                            8'(VEC_SHARED + 8'd1 + {3'b000, first});

  always_comb
    case (widx)
      3'd0:    rdata = mask_q;
      3'd1:    rdata = pend;
      3'd2:    rdata = masked;
      3'd3:    rdata = nmi_stat;
      default: rdata = '0;
    endcase

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] irq_lines,
  input logic        irq_req,
  input logic [7:0]  irq_vec,
  input logic        nmi_req,
  input logic [31:0] mask_q
);

  a_r1_reset_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask_q == 32'd0));

  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd0) |=> (mask_q == $past(wdata)));

  a_r3_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] != 3'd0) |=> $stable(mask_q));

  a_r8_quiet_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 8'h00));

  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= 8'h30 && irq_vec <= 8'h4f));

  a_r9_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (irq_lines[31] | irq_lines[30]));

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_lines(irq_lines), .irq_req(irq_req), .irq_vec(irq_vec),
  .nmi_req(nmi_req), .mask_q(mask_q)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] irq_lines = 0;
  logic [31:0] rdata;
  logic        irq_req, nmi_req;
  logic [7:0]  irq_vec;

  int compared = 0, mismatched = 0;
  logic [31:0] m_mask = 0;

  always #10 clk = ~clk;

  irq_vec_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines), .irq_req(irq_req),
    .irq_vec(irq_vec), .nmi_req(nmi_req));

  always @(posedge clk)
    if (!rst_n) m_mask <= 0;
    else if (wr_en && addr[4:2] == 0) m_mask <= wdata;

  task automatic compare(string tag);
    logic [31:0] p = 0, n = 0, mk, e_rd;
    logic [7:0] e_vec = 0;
    logic e_req;
    int cnt;
    for (int k = 1; k <= 29; k++) if (irq_lines[k]) p[k-1] = 1'b1;
    for (int k = 30; k <= 31; k++) if (irq_lines[k]) n[k] = 1'b1;
    mk = p & m_mask;
    cnt = $countones(mk);
    e_req = 0;
    if (cnt > 1) begin e_req = 1; e_vec = 8'h30; end
    else if (cnt == 1)
      for (int k = 0; k <= 30; k++) if (mk[k]) begin e_req = 1; e_vec = 8'(8'h31 + k); end
    case (addr[4:2])
      0: e_rd = m_mask;
      1: e_rd = p;
      2: e_rd = mk;
      3: e_rd = n;
      default: e_rd = 0;
    endcase
    compared++;
    if (rdata !== e_rd || irq_req !== e_req || irq_vec !== e_vec || nmi_req !== (n != 0)) begin
      mismatched++;
      $display("FAIL %s: rdata=%h req=%b vec=%h nmi=%b expected rdata=%h req=%b vec=%h nmi=%b",
        tag, rdata, irq_req, irq_vec, nmi_req, e_rd, e_req, e_vec, n != 0);
    end
  endtask

  task automatic step(logic [31:0] lines, logic we, logic [4:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    irq_lines = lines; wr_en = we; addr = a; wdata = d;
    #5 compare(tag);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    step(32'h0000_0FFE, 0, 5'd0,  0, "R1 reset mask zero");
    step(32'h0000_0FFE, 0, 5'd8,  0, "R1 no request with mask zero");
    step(32'h0, 1, 5'd0, 32'hFFFF_FFFF, "R2 mask write");
    step(32'h0, 0, 5'd0, 0, "R2 mask readback");
    step(32'h0, 0, 5'd4, 0, "R8 idle");
    step(32'h0000_0020, 0, 5'd4, 0, "R4 R6 line5 single");
    step(32'h0000_0028, 0, 5'd8, 0, "R7 two sources");
    step(32'h0000_0001, 0, 5'd4, 0, "R4 line0 ignored");
    step(32'h2000_0000, 0, 5'd4, 0, "R6 line29 bit28");
    step(32'h0000_0002, 0, 5'd8, 0, "R6 line1 bit0");
    step(32'h0000_0000, 0, 5'd8, 0, "R4 R11 level drop same cycle");
    step(32'h0000_0006, 1, 5'd0, 32'h0000_0002, "R2 partial mask write");
    step(32'h0000_0006, 0, 5'd8, 0, "R5 masked partial");
    step(32'h0000_0006, 0, 5'd4, 0, "R5 raw unaffected by mask");
    step(32'h0000_0004, 0, 5'd8, 0, "R8 masked source only");
    step(32'h0000_0004, 1, 5'd4,  32'hFFFF_FFFF, "R3 write word1");
    step(32'h0000_0004, 1, 5'd8,  32'hFFFF_FFFF, "R3 write word2");
    step(32'h0000_0004, 1, 5'd12, 32'hFFFF_FFFF, "R3 write word3");
    step(32'h0000_0004, 1, 5'd16, 32'hFFFF_FFFF, "R3 write word4");
    step(32'h0000_0004, 0, 5'd0,  0, "R3 mask unchanged");
    step(32'hC000_0000, 0, 5'd12, 0, "R9 nmi both lines");
    step(32'h4000_0000, 0, 5'd4,  0, "R9 nmi not pending");
    step(32'h8000_0000, 1, 5'd0,  32'hFFFF_FFFF, "R9 nmi while mask set");
    step(32'h8000_0000, 0, 5'd12, 0, "R9 nmi ignores mask");
    step(32'h8000_0004, 0, 5'd12, 0, "R11 mixed nmi and irq");
    step(32'h0, 0, 5'd12, 0, "R9 nmi clears");
    step(32'hFFFF_FFFF, 0, 5'd16, 0, "R10 spare word zero");
    step(32'hFFFF_FFFF, 0, 5'd20, 0, "R10 word5 zero");
    step(32'hFFFF_FFFF, 0, 5'd28, 0, "R10 word7 zero");
    step(32'h0010_0000, 0, 5'd8, 0, "R6 line20 single");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule